// File: doc/BRIEF.md
# Back-EMF Sample-and-Hold Sequencer

This block decides when a monitor output for a stepper coil voltage samples and when it holds. The coil voltage arrives as an unsigned digital word on every clock. The voltage carries useful back-EMF information only while the coil current is zero, during a zero crossing between micro-steps. Sampling moments come from a PWM sample strobe. A sample is taken only when that strobe coincides with the coil-current-zero flag.

A transparency bit selects one of two presentations. In tracking mode the output word follows each sample as it is taken, so the coil-voltage transient is visible. In settled mode the samples go into a private register. The output is loaded only when the zero-current window closes, and it then shows the last sample of the window with no transient. A gain bit scales the value written to the output by one half or by one quarter. The block also drives sample and hold enable pulses for the analog switches that follow it. Between updates the output keeps its last value.

Top module: `bemf_sh_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `level_o` is 0 and `sample_en_o` and `hold_en_o` are 0.
- R2: At a clock edge where `coil_zero_i`, `pwm_strobe_i` and `trk_mode_i` are all 1, `level_o` takes the scaled `vcoil_i` from that edge in the following cycle.
- R3: With `trk_mode_i` = 0, `level_o` does not change at any edge where `coil_zero_i` is 1.
- R4: A window ends at an edge where `coil_zero_i` is 0 and was 1 at the previous edge. If `trk_mode_i` is 0 at that edge and at least one sample was taken in the window, `level_o` takes the scaled value of the last sample.
- R5: A window that ends with no sample taken during it leaves `level_o` unchanged.
- R6: A strobe while `coil_zero_i` is 0 takes no sample. `level_o` is unchanged and `sample_en_o` stays 0.
- R7: The scaling uses `gain_sel_i` as it is at the loading edge. A value of 0 shifts right by 1 (divide by 2), and a value of 1 shifts right by 2 (divide by 4).
- R8: `sample_en_o` is 1 in exactly the cycles that follow an edge where a sample was taken (`coil_zero_i` and `pwm_strobe_i` both 1).
- R9: `hold_en_o` is 1 in exactly the cycles that follow an edge at which `level_o` was loaded. `level_o` never changes without `hold_en_o` being 1.
- R10: If `trk_mode_i` is 1 at the edge that ends a window, no copy from the private sample register takes place, and the pending sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_strobe_i | input | 1 | PWM sampling strobe |
| coil_zero_i | input | 1 | Coil current is zero |
| trk_mode_i | input | 1 | 1 = tracking (transparent), 0 = settled |
| gain_sel_i | input | 1 | 0 = divide by 2, 1 = divide by 4 |
| vcoil_i | input | VW | Digitized coil voltage, unsigned |
| level_o | output | VW | Held, scaled back-EMF word |
| sample_en_o | output | 1 | Sample switch enable pulse |
| hold_en_o | output | 1 | Hold switch enable pulse |

## Verification
Suppose the window register tracked the zero flag wrongly. Settled-mode copies would then appear a cycle off, or not at all, and the wrong value would show on `level_o` one cycle after the window closes. A stale validity flag in the sample register shows up at the end of the next window with no samples, as an unexpected update. The bench compares all three outputs with a reference model on every cycle, so any such fault is seen within one cycle of the edge where it first matters. Directed windows cover empty windows, mode changes at the closing edge and gain changes at the closing edge.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

    // Divider choice for the word written to the output register.
    typedef enum logic {
        GAIN_HALF    = 1'b0,
        GAIN_QUARTER = 1'b1
    } bemf_gain_e;

    // Source of a load into the output register.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LIVE  = 2'd1,
        SRC_STORE = 2'd2
    } bemf_src_e;

endpackage

// File: rtl/bemf_window.sv
// Tracks the zero-current window. Produces the capture qualifier and the
// one-cycle window-close indication.
module bemf_window (
    input  logic clk,
    input  logic rst_n,
    input  logic coil_zero_i,
    input  logic pwm_strobe_i,
    output logic capture_o,
    output logic win_end_o
);

    typedef struct packed {
        logic zero;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.zero = coil_zero_i;
        capture_o = coil_zero_i & pwm_strobe_i;
        win_end_o = st_q.zero & ~coil_zero_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bemf_sampler.sv
// Private sample register: keeps the latest raw capture of the window and
// whether the window has produced one.
module bemf_sampler #(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          win_end_i,
    input  logic [VW-1:0] vcoil_i,
    output logic [VW-1:0] samp_o,
    output logic          have_o
);

    typedef struct packed {
        logic          have;
        logic [VW-1:0] word;
    } smp_st_t;

    smp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.word = vcoil_i;
            st_d.have = 1'b1;
        end else if (win_end_i) begin
            st_d.have = 1'b0;
        end
        samp_o = st_q.word;
        have_o = st_q.have;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bemf_scale.sv
// Divider by right shift. The amounts are parameters; a shift of zero
// passes the word straight through.
module bemf_scale #(
    parameter int VW    = 10,
    parameter int SH_LO = 1,
    parameter int SH_HI = 2
) (
    input  logic                   gain_i,
    input  logic [VW-1:0]          word_i,
    output logic [VW-1:0]          word_o
);
    import bemf_pkg::*;

    logic [VW-1:0] lo_w, hi_w;

    generate
        if (SH_LO == 0) begin : g_lo_pass
            assign lo_w = word_i;
        end else begin : g_lo_shift
            assign lo_w = word_i >> SH_LO;
        end
        if (SH_HI == 0) begin : g_hi_pass
            assign hi_w = word_i;
        end else begin : g_hi_shift
            assign hi_w = word_i >> SH_HI;
        end
    endgenerate

    always_comb begin
        if (bemf_gain_e'(gain_i) == GAIN_QUARTER) begin
            word_o = hi_w;
        end else begin
            word_o = lo_w;
        end
    end

endmodule

// File: rtl/bemf_hold.sv
// Output register with its switch enables. Picks the load source by mode
// and scales it on the way in.
module bemf_hold #(
    parameter int VW    = 10,
    parameter int SH_LO = 1,
    parameter int SH_HI = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          win_end_i,
    input  logic          trk_i,
    input  logic          gain_i,
    input  logic [VW-1:0] vcoil_i,
    input  logic [VW-1:0] samp_i,
    input  logic          have_i,
    output logic [VW-1:0] level_o,
    output logic          sample_en_o,
    output logic          hold_en_o
);
    import bemf_pkg::*;

    typedef struct packed {
        logic [VW-1:0] level;
        logic          sen;
        logic          hen;
    } hold_st_t;

    hold_st_t      st_d, st_q;
    bemf_src_e     src_w;
    logic [VW-1:0] raw_w;
    logic [VW-1:0] scaled_w;

    always_comb begin
        if (capture_i && trk_i) begin
            src_w = SRC_LIVE;
        end else if (win_end_i && !trk_i && have_i) begin
            src_w = SRC_STORE;
        end else begin
            src_w = SRC_NONE;
        end
        raw_w = (src_w == SRC_LIVE) ? vcoil_i : samp_i;
    end

    bemf_scale #(
        .VW    (VW),
        .SH_LO (SH_LO),
        .SH_HI (SH_HI)
    ) i_scale (
        .gain_i (gain_i),
        .word_i (raw_w),
        .word_o (scaled_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sen = capture_i;
        st_d.hen = (src_w != SRC_NONE);
        if (src_w != SRC_NONE) begin
            st_d.level = scaled_w;
        end
        level_o     = st_q.level;
        sample_en_o = st_q.sen;
        hold_en_o   = st_q.hen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bemf_sh_seq.sv
module bemf_sh_seq #(
    parameter int VW    = 10,
    parameter int SH_LO = 1,
    parameter int SH_HI = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_strobe_i,
    input  logic          coil_zero_i,
    input  logic          trk_mode_i,
    input  logic          gain_sel_i,
    input  logic [VW-1:0] vcoil_i,
    output logic [VW-1:0] level_o,
    output logic          sample_en_o,
    output logic          hold_en_o
);

    logic          capture_w;
    logic          win_end_w;
    logic [VW-1:0] samp_w;
    logic          have_w;

    bemf_window i_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .coil_zero_i  (coil_zero_i),
        .pwm_strobe_i (pwm_strobe_i),
        .capture_o    (capture_w),
        .win_end_o    (win_end_w)
    );

    bemf_sampler #(.VW(VW)) i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_w),
        .win_end_i (win_end_w),
        .vcoil_i   (vcoil_i),
        .samp_o    (samp_w),
        .have_o    (have_w)
    );

    bemf_hold #(
        .VW    (VW),
        .SH_LO (SH_LO),
        .SH_HI (SH_HI)
    ) i_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (capture_w),
        .win_end_i   (win_end_w),
        .trk_i       (trk_mode_i),
        .gain_i      (gain_sel_i),
        .vcoil_i     (vcoil_i),
        .samp_i      (samp_w),
        .have_i      (have_w),
        .level_o     (level_o),
        .sample_en_o (sample_en_o),
        .hold_en_o   (hold_en_o)
    );

endmodule

// File: rtl/bemf_sh_seq_chk.sv
module bemf_sh_seq_chk #(
    parameter int VW    = 10,
    parameter int SH_LO = 1,
    parameter int SH_HI = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwm_strobe_i,
    input logic          coil_zero_i,
    input logic          trk_mode_i,
    input logic          gain_sel_i,
    input logic [VW-1:0] vcoil_i,
    input logic [VW-1:0] level_o,
    input logic          sample_en_o,
    input logic          hold_en_o
);

    p_reset_zero_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (level_o == '0 && !sample_en_o && !hold_en_o));

    p_track_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_zero_i && pwm_strobe_i && trk_mode_i) |=>
        (level_o == ($past(gain_sel_i) ? ($past(vcoil_i) >> SH_HI)
                                       : ($past(vcoil_i) >> SH_LO))));

    p_settled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_zero_i && !trk_mode_i) |=> $stable(level_o));

    p_no_zero_no_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !coil_zero_i |=> !sample_en_o);

    p_sample_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_zero_i && pwm_strobe_i) |=> sample_en_o);

    p_change_needs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> hold_en_o);

endmodule

bind bemf_sh_seq bemf_sh_seq_chk #(
    .VW    (VW),
    .SH_LO (SH_LO),
    .SH_HI (SH_HI)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_strobe_i (pwm_strobe_i),
    .coil_zero_i  (coil_zero_i),
    .trk_mode_i   (trk_mode_i),
    .gain_sel_i   (gain_sel_i),
    .vcoil_i      (vcoil_i),
    .level_o      (level_o),
    .sample_en_o  (sample_en_o),
    .hold_en_o    (hold_en_o)
);

// File: tb/test_bemf_sh_seq.sv
module test_bemf_sh_seq;
    localparam int VW = 10;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwm_strobe_i, coil_zero_i, trk_mode_i, gain_sel_i;
    logic [VW-1:0] vcoil_i;
    logic [VW-1:0] level_o;
    logic          sample_en_o, hold_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference state
    logic [VW-1:0] m_level, m_samp;
    logic          m_have, m_zprev, m_sen, m_hen;
    string         m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    bemf_sh_seq #(.VW(VW)) i_bemf_sh_seq (
        .clk(clk), .rst_n(rst_n), .pwm_strobe_i(pwm_strobe_i),
        .coil_zero_i(coil_zero_i), .trk_mode_i(trk_mode_i),
        .gain_sel_i(gain_sel_i), .vcoil_i(vcoil_i), .level_o(level_o),
        .sample_en_o(sample_en_o), .hold_en_o(hold_en_o)
    );

    function automatic logic [VW-1:0] scale(input logic [VW-1:0] v, input logic g);
        return g ? (v >> 2) : (v >> 1); // R7
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic z, input logic s, input logic t,
                        input logic g, input logic [VW-1:0] v);
        logic cap, wend;
        coil_zero_i = z; pwm_strobe_i = s; trk_mode_i = t;
        gain_sel_i = g; vcoil_i = v;
        @(posedge clk);
        cap  = z & s;
        wend = m_zprev & ~z;
        m_hen = 1'b0;
        if (cap && t) begin
            m_level = scale(v, g); m_hen = 1'b1; m_tag = "R2";
        end else if (wend && !t && m_have) begin
            m_level = scale(m_samp, g); m_hen = 1'b1; m_tag = "R4";
        end else if (wend && t) begin
            m_tag = "R10";
        end else if (wend) begin
            m_tag = "R5";
        end else if (z && !t) begin
            m_tag = "R3";
        end else if (s && !z) begin
            m_tag = "R6";
        end else begin
            m_tag = "R9";
        end
        if (cap) begin
            m_samp = v; m_have = 1'b1;
        end else if (wend) begin
            m_have = 1'b0;
        end
        m_sen   = cap;
        m_zprev = z;
        @(negedge clk);
        chk(m_tag, int'(level_o), int'(m_level));
        chk("R8", int'(sample_en_o), int'(m_sen));
        chk("R9", int'(hold_en_o), int'(m_hen));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pwm_strobe_i = 0; coil_zero_i = 0; trk_mode_i = 0; gain_sel_i = 0;
        vcoil_i = '0;
        m_level = '0; m_samp = '0; m_have = 0; m_zprev = 0; m_sen = 0; m_hen = 0;
        m_tag = "R1";
        repeat (3) @(negedge clk);
        chk("R1", int'(level_o), 0);
        chk("R1", int'(sample_en_o), 0);
        chk("R1", int'(hold_en_o), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 10'd0);
        chk("R1", int'(level_o), 0);

        // tracking window, half gain
        step(1, 1, 1, 0, 10'd600);
        chk("R2", int'(level_o), 300);
        step(0, 0, 1, 0, 10'd0);
        // settled window with several strobes
        step(1, 1, 0, 0, 10'd400);
        step(1, 0, 0, 0, 10'd999);
        step(1, 1, 0, 0, 10'd200);
        chk("R3", int'(level_o), 300);
        step(0, 0, 0, 1, 10'd777);
        chk("R4", int'(level_o), 50);   // R7: 200 >> 2 at closing edge
        // empty window
        step(1, 0, 0, 0, 10'd5);
        step(0, 0, 0, 0, 10'd5);
        chk("R5", int'(level_o), 50);
        // strobe outside window
        step(0, 1, 1, 0, 10'd1000);
        chk("R6", int'(level_o), 50);
        chk("R6", int'(sample_en_o), 0);
        // mode flips to tracking on the closing edge
        step(1, 1, 0, 0, 10'd800);
        step(0, 0, 1, 0, 10'd0);
        chk("R10", int'(level_o), 50);
        chk("R10", int'(hold_en_o), 0);
        // tracking, quarter gain, real-time follow
        step(1, 1, 1, 1, 10'd1023);
        chk("R7", int'(level_o), 255);
        chk("R8", int'(sample_en_o), 1);
        chk("R9", int'(hold_en_o), 1);
        step(1, 1, 1, 1, 10'd100);
        chk("R2", int'(level_o), 25);
        step(0, 0, 1, 1, 10'd0);

        // constrained random
        void'($urandom(32'd1234));
        begin
            logic z, t, g;
            z = 0; t = 0; g = 0;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom_range(7) == 0)  z = ~z;
                if ($urandom_range(31) == 0) t = ~t;
                if ($urandom_range(15) == 0) g = ~g;
                step(z, ($urandom_range(2) == 0), t, g, VW'($urandom));
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule